// File: doc/BRIEF.md
# Packed Double-Precision Compare Unit

This unit compares two 128-bit operands. Each operand holds two IEEE-754 binary64 values, one in each 64-bit lane. Each lane of the first operand (A) is compared with the same lane of the second operand (B), using a relation chosen by an 8-bit immediate. Every lane result is written as a full-width mask: all ones when the relation holds and all zeros when it does not. Because the mask is a plain bit pattern, a later select or blend step can use it directly.

Beside the mask, the unit reports two status flags for the whole operation. The invalid-operation flag follows the NaN rules of the chosen predicate. The denormal-operand flag is set when any compared value is subnormal. The mask and both flags are captured together in output registers, on a clock edge where the input strobe is high. Between strobes they hold their last values.

Top module: `fpcmp_packed`

## Requirements
- R1: Lane i covers operand bits [64i+63:64i], and each lane's result depends only on that lane of A and of B.
- R2: Every 64-bit lane of the mask is either all ones (relation true) or all zeros (relation false).
- R3: imm_i[2:0] selects the predicate: 0 EQ, 1 LT, 2 LE, 3 UNORD, 4 NEQ, 5 NLT, 6 NLE, 7 ORD. imm_i[7:3] has no effect on the mask or the flags.
- R4: Non-NaN values compare by their numeric value, with A on the left: LT is A<B, LE is A<=B, NLT is not(A<B), NLE is not(A<=B). +0.0 equals -0.0, and subnormals compare exactly with no flush to zero.
- R5: A value is a NaN when its exponent bits [62:52] are all ones and its fraction bits [51:0] are nonzero. The NaN is quiet when bit 51 is 1 and signaling when it is 0. An infinity is not a NaN.
- R6: A lane with at least one NaN is unordered. For such a lane, EQ, LT, LE and ORD give false, and NEQ, NLT, NLE and UNORD give true.
- R7: invalid_o is set whenever any of the four compared values is a signaling NaN, whatever the predicate.
- R8: A quiet NaN sets invalid_o only for the LT, LE, NLT and NLE predicates. For EQ, NEQ, UNORD and ORD it does not.
- R9: denormal_o is set when any compared value has a zero exponent field and a nonzero fraction.
- R10: On a rising edge with valid_i high, mask_o, invalid_o and denormal_o take the new result, and valid_o is high for the following cycle. With valid_i low they hold their values and valid_o is low. Reset clears all outputs to zero.
- R11: Infinities order normally: -inf is below every finite value, and +inf equals +inf.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Capture strobe for the operands and the immediate |
| a_i | input | 128 | First operand A, two binary64 lanes |
| b_i | input | 128 | Second operand B, two binary64 lanes |
| imm_i | input | 8 | Predicate immediate |
| valid_o | output | 1 | Result was captured on the previous edge |
| mask_o | output | 128 | Per-lane all-ones / all-zeros result mask |
| invalid_o | output | 1 | Invalid-operation flag, OR of both lanes |
| denormal_o | output | 1 | Denormal-operand flag, OR of both lanes |

## Verification
The assertions assume that valid_i, both operands and the immediate carry known values at every edge after reset. They place no other limit on the operand bit patterns, so NaN payloads, either sign and infinities are all legal. The stimulus meets this by changing inputs only on the falling clock edge, driving every field in every cycle, and holding reset for several cycles before the first strobe. Each capture is followed by an idle cycle whose inputs are deliberately altered, so that the hold behaviour is exercised under changing inputs.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic qnan;
    logic zero;
    logic sub;
  } fp_class_t;

  // Relational predicates treat a quiet NaN as an invalid operand
  function automatic logic pred_traps_qnan(pred_e p);
    return p inside {PRED_LT, PRED_LE, PRED_NLT, PRED_NLE};
  endfunction

endpackage

// File: rtl/fpcmp_pred_dec.sv
module fpcmp_pred_dec
  import fpcmp_pkg::*;
(
  input  logic [7:0] imm_i,
  output pred_e      pred_o,
  output logic       qnan_traps_o
);

  // upper immediate bits are reserved
  logic unused_imm_hi;
  assign unused_imm_hi = ^imm_i[7:3];

  assign pred_o       = pred_e'(imm_i[2:0]);
  assign qnan_traps_o = pred_traps_qnan(pred_o);

endmodule

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0]   val_i,
  output fp_class_t               cls_o,
  output logic [EXP_W+FRAC_W-1:0] mag_o
);

  localparam int W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic exp_ones, exp_zero, frac_nz;

  assign exp_f    = val_i[W-2 -: EXP_W];
  assign frac_f   = val_i[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign exp_zero = ~|exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls_o.sign = val_i[W-1];
    cls_o.nan  = exp_ones & frac_nz;
    cls_o.qnan = exp_ones & frac_nz & frac_f[FRAC_W-1];
    cls_o.snan = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
    cls_o.zero = exp_zero & ~frac_nz;
    cls_o.sub  = exp_zero & frac_nz;
  end

  assign mag_o = val_i[W-2:0];

endmodule

// File: rtl/fpcmp_lane.sv
module fpcmp_lane
  import fpcmp_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [EXP_W+FRAC_W:0] a_i,
  input  logic [EXP_W+FRAC_W:0] b_i,
  input  pred_e                 pred_i,
  output logic                  hit_o,
  output logic                  snan_o,
  output logic                  qnan_o,
  output logic                  sub_o
);

  localparam int MAG_W = EXP_W + FRAC_W;

  fp_class_t        cls_a, cls_b;
  logic [MAG_W-1:0] mag_a, mag_b;

  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_a (
    .val_i(a_i), .cls_o(cls_a), .mag_o(mag_a)
  );
  fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls_b (
    .val_i(b_i), .cls_o(cls_b), .mag_o(mag_b)
  );

  logic unord, both_zero, eq_raw, lt_raw, eq, lt, le;
  logic mag_lt, mag_gt;

  assign unord     = cls_a.nan | cls_b.nan;
  assign both_zero = cls_a.zero & cls_b.zero;
  assign mag_lt    = mag_a < mag_b;
  assign mag_gt    = mag_a > mag_b;
  assign eq_raw    = both_zero | (a_i == b_i);

  // sign-magnitude ordering; +0/-0 pair is never less-than
  always_comb begin
    if (both_zero)                  lt_raw = 1'b0;
    else if (cls_a.sign != cls_b.sign) lt_raw = cls_a.sign;
    else if (cls_a.sign)            lt_raw = mag_gt;
    else                            lt_raw = mag_lt;
  end

  assign eq = ~unord & eq_raw;
  assign lt = ~unord & lt_raw;
  assign le = eq | lt;

  always_comb begin
    unique case (pred_i)
      PRED_EQ:    hit_o = eq;
      PRED_LT:    hit_o = lt;
      PRED_LE:    hit_o = le;
      PRED_UNORD: hit_o = unord;
      PRED_NEQ:   hit_o = ~eq;
      PRED_NLT:   hit_o = ~lt;
      PRED_NLE:   hit_o = ~le;
      PRED_ORD:   hit_o = ~unord;
      default:    hit_o = 1'b0;
    endcase
  end

  assign snan_o = cls_a.snan | cls_b.snan;
  assign qnan_o = cls_a.qnan | cls_b.qnan;
  assign sub_o  = cls_a.sub  | cls_b.sub;

  AST_EQ_LT_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eq && lt)); // R4

  AST_UNORD_NOT_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unord |-> (!eq && !lt)); // R6

  AST_SIGNED_ZERO_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cls_a.zero && cls_b.zero) |-> eq); // R4

endmodule

// File: rtl/fpcmp_packed.sv
module fpcmp_packed
  import fpcmp_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  valid_i,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]     a_i,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]     b_i,
  input  logic [7:0]                            imm_i,
  output logic                                  valid_o,
  output logic [LANES*(1+EXP_W+FRAC_W)-1:0]     mask_o,
  output logic                                  invalid_o,
  output logic                                  denormal_o
);

  localparam int LANE_W = 1 + EXP_W + FRAC_W;
  localparam int DATA_W = LANES * LANE_W;

  pred_e             pred;
  logic              qnan_traps;
  logic [LANES-1:0]  lane_hit, lane_snan, lane_qnan, lane_sub;
  logic [DATA_W-1:0] mask_d;
  logic              invalid_d, denormal_d;

  fpcmp_pred_dec u_dec (
    .imm_i        (imm_i),
    .pred_o       (pred),
    .qnan_traps_o (qnan_traps)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    fpcmp_lane #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .a_i    (a_i[i*LANE_W +: LANE_W]),
      .b_i    (b_i[i*LANE_W +: LANE_W]),
      .pred_i (pred),
      .hit_o  (lane_hit[i]),
      .snan_o (lane_snan[i]),
      .qnan_o (lane_qnan[i]),
      .sub_o  (lane_sub[i])
    );
    assign mask_d[i*LANE_W +: LANE_W] = {LANE_W{lane_hit[i]}};

    AST_MASK_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_o[i*LANE_W +: LANE_W] == '0) || (mask_o[i*LANE_W +: LANE_W] == '1)); // R2
  end

  assign invalid_d  = (|lane_snan) | ((|lane_qnan) & qnan_traps);
  assign denormal_d = |lane_sub;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      mask_o     <= '0;
      invalid_o  <= 1'b0;
      denormal_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mask_o     <= mask_d;
        invalid_o  <= invalid_d;
        denormal_o <= denormal_d;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(mask_o) && $stable(invalid_o) && $stable(denormal_o))); // R10

  AST_SNAN_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (|lane_snan)) |=> invalid_o); // R7

  AST_QNAN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !(|lane_snan) && !qnan_traps) |=> !invalid_o); // R8

  AST_SUB_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (|lane_sub)) |=> denormal_o); // R9

endmodule

// File: tb/tb_fpcmp_packed.sv
`timescale 1ns/1ps
module tb_fpcmp_packed;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic [7:0]   imm = '0;
  logic         valid_o, invalid_o, denormal_o;
  logic [127:0] mask_o;

  fpcmp_packed dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .a_i(a), .b_i(b), .imm_i(imm),
    .valid_o(valid_o), .mask_o(mask_o), .invalid_o(invalid_o), .denormal_o(denormal_o)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit checking = 0;
  bit exp_hit0 = 0, exp_hit1 = 0, exp_inv = 0, exp_den = 0, exp_vld = 0;
  string cur_tag = "R10", exp_tag = "R10";

  localparam logic [63:0] P1   = 64'h3FF0000000000000;
  localparam logic [63:0] P2   = 64'h4000000000000000;
  localparam logic [63:0] N1   = 64'hBFF0000000000000;
  localparam logic [63:0] N2   = 64'hC000000000000000;
  localparam logic [63:0] PZ   = 64'h0000000000000000;
  localparam logic [63:0] NZ   = 64'h8000000000000000;
  localparam logic [63:0] S1   = 64'h0000000000000001;
  localparam logic [63:0] S2   = 64'h0000000000000002;
  localparam logic [63:0] NS1  = 64'h8000000000000001;
  localparam logic [63:0] PINF = 64'h7FF0000000000000;
  localparam logic [63:0] NINF = 64'hFFF0000000000000;
  localparam logic [63:0] QN   = 64'h7FF8000000000000;
  localparam logic [63:0] NQN  = 64'hFFF8000000000001;
  localparam logic [63:0] SN   = 64'h7FF0000000000001;

  function automatic bit f_nan(logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic bit f_snan(logic [63:0] v);
    return f_nan(v) && !v[51];
  endfunction
  function automatic bit f_sub(logic [63:0] v);
    return (v[62:52] == 0) && (v[51:0] != 0);
  endfunction
  function automatic bit f_hit(logic [63:0] x, logic [63:0] y, int p);
    real rx, ry;
    if (f_nan(x) || f_nan(y)) return (p == 3) || (p == 4) || (p == 5) || (p == 6);
    rx = $bitstoreal(x);
    ry = $bitstoreal(y);
    case (p)
      0: return rx == ry;
      1: return rx < ry;
      2: return rx <= ry;
      3: return 1'b0;
      4: return rx != ry;
      5: return !(rx < ry);
      6: return !(rx <= ry);
      default: return 1'b1;
    endcase
  endfunction

  // reference model, sampled on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_hit0 = 0; exp_hit1 = 0; exp_inv = 0; exp_den = 0; exp_vld = 0;
    end else begin
      exp_vld = valid;
      if (valid) begin
        int p;
        bit any_s, any_q;
        p = int'(imm[2:0]);
        exp_hit0 = f_hit(a[63:0], b[63:0], p);
        exp_hit1 = f_hit(a[127:64], b[127:64], p);
        any_s = f_snan(a[63:0]) || f_snan(b[63:0]) || f_snan(a[127:64]) || f_snan(b[127:64]);
        any_q = (f_nan(a[63:0]) && !f_snan(a[63:0])) || (f_nan(b[63:0]) && !f_snan(b[63:0])) ||
                (f_nan(a[127:64]) && !f_snan(a[127:64])) || (f_nan(b[127:64]) && !f_snan(b[127:64]));
        exp_inv = any_s || (any_q && (p == 1 || p == 2 || p == 5 || p == 6));
        exp_den = f_sub(a[63:0]) || f_sub(b[63:0]) || f_sub(a[127:64]) || f_sub(b[127:64]);
        exp_tag = cur_tag;
      end else begin
        exp_tag = "R10";
      end
    end
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h imm=%h t=%0t", req, act, exv, imm, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) begin
      chk(mask_o[63:0] == {64{exp_hit0}}, {exp_tag, " lane0"}, mask_o[63:0], {64{exp_hit0}});
      chk(mask_o[127:64] == {64{exp_hit1}}, {exp_tag, " lane1"}, mask_o[127:64], {64{exp_hit1}});
      chk(invalid_o == exp_inv, "R7 R8 invalid", 64'(invalid_o), 64'(exp_inv));
      chk(denormal_o == exp_den, "R9 denormal", 64'(denormal_o), 64'(exp_den));
      chk(valid_o == exp_vld, "R10 valid", 64'(valid_o), 64'(exp_vld));
    end
  end

  task automatic run_vec(logic [63:0] a0, logic [63:0] b0, logic [63:0] a1, logic [63:0] b1,
                         string tag);
    for (int hi = 0; hi < 2; hi++) begin
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        a = {a1, a0}; b = {b1, b0};
        imm = (hi != 0) ? (8'hA8 | 8'(p)) : 8'(p);  // R3 reserved bits
        cur_tag = tag;
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        a = ~a; b = {b[63:0], b[127:64]}; imm = ~imm;  // idle: R10 hold
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(mask_o == '0, "R10 reset mask", mask_o[63:0], 64'h0);
    chk({valid_o, invalid_o, denormal_o} == 3'b000, "R10 reset flags",
        64'({valid_o, invalid_o, denormal_o}), 64'h0);
    rst_n = 1'b1;
    checking = 1'b1;
    run_vec(P1, P2, P2, P1, "R1");
    run_vec(N1, P1, N2, N1, "R4");
    run_vec(PZ, NZ, P1, P1, "R4 zero");
    run_vec(S1, S2, NS1, PZ, "R9");
    run_vec(QN, P1, P1, P1, "R8");
    run_vec(P1, P2, P1, SN, "R7");
    run_vec(NINF, N2, PINF, PINF, "R11");
    run_vec(P1, QN, QN, QN, "R6");
    run_vec(PINF, SN, NQN, N1, "R5");
    run_vec(S2, S1, NZ, NS1, "R2");
    @(negedge clk);
    checking = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule